// File: doc/BRIEF.md
# Chipset Power Mode Controller

This block sequences a memory and bus bridge through its power states. After a hard reset it is in full-on, with every functional unit enabled. Software writes a mode-request register to ask for doze, nap or sleep. An external pin places the bridge in suspend.

The block drives one enable output for each unit: core logic, PCI address decode, DRAM refresh, processor bus-request monitoring and the core clock. Three inputs wake it: hard reset, a PCI hit on system memory, and a processor bus request. Which input wakes it, and from which state, decides what follows. A temporary wake serves one access and then, on the `access_done` strobe, drops back to the low-power state it came from. A processor wake from nap stays in full-on. The exits from sleep and suspend, and a loss of lock during nap, wait in a pending state until `pll_locked` is asserted.

PLL control, refresh timing and the bus protocols are outside the block. They appear here only as strobes and enables.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, `state_out` is 0 (full-on), all five enables are 1 and `req_mode_q` is 0.
- R2: State codes are 0 full-on, 1 doze, 2 nap, 3 sleep, 4 suspend, 5 temporary wake and 6 wake pending. Request codes are 0 full-on, 1 doze, 2 nap and 3 sleep. A write with `req_we` loads `req_mode_q` at the next edge, and the state follows one edge later. While `suspend_in` is high, full-on, doze, nap and sleep all move to suspend.
- R3: In doze and nap, `en_pci_dec`, `en_refresh` and `en_busreq_mon` are 1, while `en_core` and `en_clk` are 0.
- R4: In doze, either `pci_mem_hit` or `cpu_bus_req` moves the block to temporary wake (5) at the next edge, with all enables 1. On `access_done` it returns to doze.
- R5: In nap, `pci_mem_hit` moves the block to temporary wake, and `access_done` returns it to nap.
- R6: In nap, `cpu_bus_req` moves the block to temporary wake, and `access_done` then leaves it in full-on.
- R7: In sleep, only `en_refresh` can be 1, and it equals `sleep_refresh_en`. `pci_mem_hit` is ignored. `cpu_bus_req` moves the block to wake pending (6).
- R8: Nap is entered only while `pll_locked` is 1. Losing lock during nap moves the block to wake pending. Wake pending holds until `pll_locked` is 1 and then moves to full-on.
- R9: Suspend has all enables 0 except `en_refresh`, which equals `sleep_refresh_en`. Suspend is left through wake pending when `suspend_in` falls.
- R10: Every move into full-on from another state clears `req_mode_q` to 0.
- R11: Hard reset returns the block to full-on from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| req_we | input | 1 | Write strobe for the mode request |
| req_mode | input | 2 | Requested mode code |
| sleep_refresh_en | input | 1 | Keeps refresh running in sleep, suspend and wake pending |
| suspend_in | input | 1 | External suspend request |
| pci_mem_hit | input | 1 | PCI access to system memory |
| cpu_bus_req | input | 1 | Processor bus request |
| access_done | input | 1 | Wake access completed |
| pll_locked | input | 1 | PLL running and locked |
| state_out | output | 3 | Current state code |
| req_mode_q | output | 2 | Mode-request register |
| en_core | output | 1 | Core logic enable |
| en_pci_dec | output | 1 | PCI address decode enable |
| en_refresh | output | 1 | DRAM refresh enable |
| en_busreq_mon | output | 1 | Bus-request monitor enable |
| en_clk | output | 1 | Core clock enable |

## Verification
The hardest situation to reach is a temporary wake whose outcome depends on two things at once: the low-power mode it came from and the source that woke it. The stimulus sweeps both low-power modes against both wake sources, and the bench predicts the final state and request value arithmetically. The PLL-lock waits are reached by dropping `pll_locked` before each wake or exit, so the pending state can be seen holding for a cycle before lock returns.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_we,
  input  logic [1:0] req_mode,
  input  logic       sleep_refresh_en,
  input  logic       suspend_in,
  input  logic       pci_mem_hit,
  input  logic       cpu_bus_req,
  input  logic       access_done,
  input  logic       pll_locked,
  output logic [2:0] state_out,
  output logic [1:0] req_mode_q,
  output logic       en_core,
  output logic       en_pci_dec,
  output logic       en_refresh,
  output logic       en_busreq_mon,
  output logic       en_clk
);
  typedef enum logic [2:0] {
    S_FULL = 3'd0, S_DOZE = 3'd1, S_NAP = 3'd2, S_SLEEP = 3'd3,
    S_SUSP = 3'd4, S_WTMP = 3'd5, S_WPEND = 3'd6
  } st_t;

  st_t  st, nxt;
  logic ret_nap, nret_nap, proc_wake, nproc_wake, clr;

  always_comb begin
    nxt = st; nret_nap = ret_nap; nproc_wake = proc_wake; clr = 1'b0;
    case (st)
      S_FULL:
        if (suspend_in) nxt = S_SUSP;
        else case (req_mode_q)
          2'd1: nxt = S_DOZE;
          2'd2: if (pll_locked) nxt = S_NAP;
          2'd3: nxt = S_SLEEP;
          default: nxt = S_FULL;
        endcase
      S_DOZE:
        if (suspend_in) nxt = S_SUSP;
        else if (pci_mem_hit || cpu_bus_req) begin
          nxt = S_WTMP; nret_nap = 1'b0; nproc_wake = 1'b0;
        end
      S_NAP:
        if (suspend_in) nxt = S_SUSP;
        else if (!pll_locked) nxt = S_WPEND;
        else if (cpu_bus_req || pci_mem_hit) begin
          nxt = S_WTMP; nret_nap = 1'b1; nproc_wake = cpu_bus_req;
        end
      S_SLEEP:
        if (suspend_in) nxt = S_SUSP;
        else if (cpu_bus_req) nxt = S_WPEND;
      S_SUSP:
        if (!suspend_in) nxt = S_WPEND;
      S_WPEND:
        if (pll_locked) begin nxt = S_FULL; clr = 1'b1; end
      S_WTMP:
        if (access_done) begin
          if (proc_wake) begin nxt = S_FULL; clr = 1'b1; end
          else nxt = ret_nap ? S_NAP : S_DOZE;
        end
      default: nxt = S_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_FULL; ret_nap <= 1'b0; proc_wake <= 1'b0; req_mode_q <= 2'd0;
    end else begin
      st <= nxt; ret_nap <= nret_nap; proc_wake <= nproc_wake;
      if (clr) req_mode_q <= 2'd0;
      else if (req_we) req_mode_q <= req_mode;
    end
  end

  wire awake = (st == S_FULL) || (st == S_WTMP);
  wire light = (st == S_DOZE) || (st == S_NAP);

  assign state_out     = st;
  assign en_core       = awake;
  assign en_clk        = awake;
  assign en_pci_dec    = awake || light;
  assign en_busreq_mon = awake || light;
  assign en_refresh    = awake || light || sleep_refresh_en;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state_out,
  input logic [1:0] req_mode_q,
  input logic       suspend_in,
  input logic       pci_mem_hit,
  input logic       cpu_bus_req,
  input logic       pll_locked
);
  assert_doze_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_out == 3'd1 && pci_mem_hit && !suspend_in) |=> state_out == 3'd5);

  assert_sleep_pci_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_out == 3'd3 && pci_mem_hit && !cpu_bus_req && !suspend_in) |=> state_out == 3'd3);

  assert_pend_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_out == 3'd6 && !pll_locked) |=> state_out == 3'd6);

  assert_suspend_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_out == 3'd4 && !suspend_in) |=> state_out == 3'd6);

  assert_full_clears_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_out != 3'd0) |=> (state_out == 3'd0 |-> req_mode_q == 2'd0));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state_out(state_out), .req_mode_q(req_mode_q),
  .suspend_in(suspend_in), .pci_mem_hit(pci_mem_hit),
  .cpu_bus_req(cpu_bus_req), .pll_locked(pll_locked)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, req_we = 0, sleep_refresh_en = 0, suspend_in = 0;
  logic pci_mem_hit = 0, cpu_bus_req = 0, access_done = 0, pll_locked = 1;
  logic [1:0] req_mode = 0;
  logic [2:0] state_out;
  logic [1:0] req_mode_q;
  logic en_core, en_pci_dec, en_refresh, en_busreq_mon, en_clk;
  int total = 0, bad = 0;

  pwr_mode_ctrl u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int ens();
    return {en_core, en_pci_dec, en_refresh, en_busreq_mon, en_clk};
  endfunction

  task automatic do_reset();
    rst_n = 0; tick(); rst_n = 1; tick();
  endtask

  task automatic go(int m);
    req_we = 1; req_mode = 2'(m); tick(); req_we = 0; tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 state", state_out, 0);
    chk("R1 enables", ens(), 5'b11111);
    chk("R1 req", req_mode_q, 0);

    for (int lp = 1; lp <= 2; lp++) begin
      for (int src = 0; src <= 1; src++) begin
        do_reset();
        go(lp);
        chk("R2 entry", state_out, lp);
        chk("R3 enables", ens(), 5'b01110);
        if (src == 0) pci_mem_hit = 1; else cpu_bus_req = 1;
        tick(); pci_mem_hit = 0; cpu_bus_req = 0;
        chk("R4 wake state", state_out, 5);
        chk("R4 wake enables", ens(), 5'b11111);
        access_done = 1; tick(); access_done = 0;
        if (lp == 2 && src == 1) chk("R6 nap cpu stays on", state_out, 0);
        else if (lp == 2) chk("R5 nap pci returns", state_out, 2);
        else chk("R4 doze returns", state_out, 1);
        chk("R10 req after wake", req_mode_q, (lp == 2 && src == 1) ? 0 : lp);
      end
    end

    for (int rb = 0; rb <= 1; rb++) begin
      do_reset();
      sleep_refresh_en = rb[0];
      go(3);
      chk("R7 sleep state", state_out, 3);
      chk("R7 sleep enables", ens(), rb ? 5'b00100 : 5'b00000);
      pci_mem_hit = 1; tick(); pci_mem_hit = 0;
      chk("R7 pci ignored", state_out, 3);
      pll_locked = 0; cpu_bus_req = 1; tick(); cpu_bus_req = 0;
      chk("R7 cpu wake pending", state_out, 6);
      tick();
      chk("R8 pending holds", state_out, 6);
      pll_locked = 1; tick();
      chk("R8 lock to full", state_out, 0);
      chk("R10 req cleared", req_mode_q, 0);
      sleep_refresh_en = 0;
    end

    do_reset();
    pll_locked = 0; go(2);
    chk("R8 nap blocked unlocked", state_out, 0);
    pll_locked = 1; tick();
    chk("R8 nap entered on lock", state_out, 2);
    pll_locked = 0; tick();
    chk("R8 lock loss pending", state_out, 6);
    pll_locked = 1; tick();
    chk("R8 relock full", state_out, 0);

    do_reset();
    sleep_refresh_en = 1; suspend_in = 1; tick();
    chk("R2 suspend entry", state_out, 4);
    chk("R9 suspend enables", ens(), 5'b00100);
    pll_locked = 0; suspend_in = 0; tick();
    chk("R9 suspend exit pending", state_out, 6);
    pll_locked = 1; tick();
    chk("R9 suspend to full", state_out, 0);
    sleep_refresh_en = 0;

    go(3);
    chk("R11 in sleep", state_out, 3);
    do_reset();
    chk("R11 reset to full", state_out, 0);
    chk("R11 enables", ens(), 5'b11111);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule